// File: doc/BRIEF.md
# Multi-Mode GPIO Port

This block is one general-purpose I/O port of up to sixteen pins, reached through a small word-addressed register interface. Each pin has its own drive mode: plain input, push-pull output, open-drain output, or quasi-bidirectional. In the quasi-bidirectional mode the pin drives a 0 strongly and, after a rising output, drives high strongly for a short boost before it falls back to a weak pull-up. The port holds the output data, a per-pin write-protect mask for that data, a per-pin digital input disable, and the mode of each pin. A pin-addressed alias window lets one access write the output bit of a single pin, or read the input level of a single pin.

For each pin the block drives an output-enable, an output value and a weak pull-up request toward an external pad model. Pad inputs pass through a two-flop synchronizer before any read path sees them, and the synchronized and gated level is also brought out as a port. A parameter lists which pins exist. A pin that does not exist reads as zero everywhere, ignores writes and never drives its pad.

Reads return data in the same cycle that `bus_en` is high with `bus_we` low. A write takes effect at the clock edge where `bus_en` and `bus_we` are both high.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset every pin is in input mode with its pad released. Output data reads as all ones on the existing pins, and the mask and the input-disable bits read as zero.
- R2: The mode register sits at byte offset 0x00 and holds a 2-bit code for pin n in bits [2n+1:2n]. Code 0 (input) releases the pad. Code 1 (push-pull) enables the pad and drives it with the output data bit.
- R3: Code 2 (open-drain) enables the pad driving 0 when the output bit is 0, and releases the pad when the bit is 1. It never drives a 1.
- R4: Code 3 (quasi-bidirectional) drives a 0 bit strongly low. When the output bit goes from 0 to 1, the pad is driven high for exactly 2 cycles. After that the output-enable is released and the weak pull-up output is asserted.
- R5: A pin whose mask bit is 1 keeps its output data bit unchanged on both full-port and alias writes. The mask register is at byte offset 0x08, with bit n for pin n.
- R6: A write to the output data register at byte offset 0x04 updates every unmasked existing bit in one access. The pads show the new data in the cycle after the write edge.
- R7: A read of byte offset 0x0C returns all pin input levels at once, with bit n for pin n. A pad level change first appears there after two clock edges.
- R8: The input-disable bit for pin n is bit n+16 of the control register at byte offset 0x10. While it is set, that pin's input reads as 0 in every read path. The low 16 bits of that register read as 0 and ignore writes.
- R9: The alias word for pin n is at byte offset 0x40 + 4n. A write sets that pin's output data bit to bit 0 of the write data and leaves the other pins unchanged. A read returns the pin's input level in bit 0, with zeros above.
- R10: Pins that do not exist read as 0 in every register and in the alias window, ignore writes, and keep their output-enable, output value, pull-up and synchronized input at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle, zero when no read is active |
| pin_i | input | NPINS | Raw pad input levels |
| pad_oe | output | NPINS | Per-pin strong-drive enable |
| pad_o | output | NPINS | Per-pin driven value |
| pad_wkpu | output | NPINS | Per-pin weak pull-up request |
| pin_sync | output | NPINS | Synchronized, disable-gated pin input |

## Verification
A wrong output data bit or mode field shows on `pad_oe`/`pad_o` in the very cycle after the write edge, so the pad checks sample there and again after the state has settled. A boost counter that is stuck or miscounted shows as a quasi pin that stays high one cycle too long or too short, so the cycle-by-cycle check around an alias write pins this down. A mask or input-disable bit held in the wrong state only becomes visible through a later write or a read. The bench therefore follows each such write with a read of the affected register, and with a read of the input register two edges after a pad change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        PM_INPUT     = 2'd0,
        PM_PUSHPULL  = 2'd1,
        PM_OPENDRAIN = 2'd2,
        PM_QUASI     = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic oe;
        logic o;
        logic wkpu;
    } pad_drv_t;

    typedef enum logic [2:0] {
        RS_NONE, RS_MODE, RS_DOUT, RS_MASK, RS_PIN, RS_CTRL, RS_ALIAS
    } reg_sel_e;

    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_DOUT  = 8'h04;
    localparam logic [7:0] OFS_MASK  = 8'h08;
    localparam logic [7:0] OFS_PIN   = 8'h0C;
    localparam logic [7:0] OFS_CTRL  = 8'h10;
    localparam logic [7:0] OFS_ALIAS = 8'h40;
    localparam int         DIS_SHIFT = 16;

    // Spread a 16-bit pin mask to the 2-bit-per-pin mode layout.
    function automatic logic [31:0] widen2(input logic [15:0] m);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < 16; k++) begin
            r[2*k]   = m[k];
            r[2*k+1] = m[k];
        end
        return r;
    endfunction

    // Pad drive for one pin, from its mode, output bit and boost state.
    function automatic pad_drv_t drive_of(input pin_mode_e m, input logic d, input logic boost);
        pad_drv_t r;
        r = '0;
        case (m)
            PM_PUSHPULL:  begin r.oe = 1'b1; r.o = d; end
            PM_OPENDRAIN: begin r.oe = ~d; end
            PM_QUASI: begin
                if (!d)         begin r.oe = 1'b1; end
                else if (boost) begin r.oe = 1'b1; r.o = 1'b1; end
                else            begin r.wkpu = 1'b1; end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_insync.sv
module gpio_insync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
    import gpio_pkg::*;
#(
    parameter int BOOST_CYC = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  pin_mode_e mode,
    input  logic      dbit,
    output pad_drv_t  drv
);
    localparam int CW = $clog2(BOOST_CYC + 1);

    logic          prev_q;
    logic [CW-1:0] cnt_q;
    logic          rise;
    logic          boost;

    // The first boost cycle comes from the rise itself; the counter covers the rest.
    assign rise  = dbit & ~prev_q;
    assign boost = rise | (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            prev_q <= dbit;
            if (!dbit)                         cnt_q <= '0;
            else if (rise && mode == PM_QUASI) cnt_q <= CW'(BOOST_CYC - 1);
            else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
        end
    end

    assign drv = drive_of(mode, dbit, boost);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int               NPINS     = 16,
    parameter logic [NPINS-1:0] IMPL_MASK = '1,
    parameter int               ADDR_W    = 8,
    parameter int               DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [NPINS-1:0]     pin_val,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [2*NPINS-1:0]   mode_q,
    output logic [NPINS-1:0]     dout_q,
    output logic [NPINS-1:0]     mask_q,
    output logic [NPINS-1:0]     dis_q
);
    localparam int PIN_W    = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam int ALIAS_LO = 2 + PIN_W;
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_DOUT  = ADDR_W'(OFS_DOUT);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_PIN   = ADDR_W'(OFS_PIN);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_ALIAS = ADDR_W'(OFS_ALIAS);
    localparam logic [31:0]          IMPL2_FULL = widen2(16'(IMPL_MASK));
    localparam logic [2*NPINS-1:0]   IMPL2      = IMPL2_FULL[2*NPINS-1:0];

    reg_sel_e          sel;
    logic [PIN_W-1:0]  apin;
    logic              alias_hit;
    logic              wr;
    logic [NPINS-1:0]  upd;
    logic [NPINS-1:0]  val;
    logic [NPINS-1:0]  dout_nxt;

    assign wr        = bus_en & bus_we;
    assign apin      = bus_addr[2 +: PIN_W];
    assign alias_hit = (bus_addr[ADDR_W-1:ALIAS_LO] == A_ALIAS[ADDR_W-1:ALIAS_LO])
                       && (bus_addr[1:0] == 2'b00) && (32'(apin) < NPINS);

    always_comb begin
        sel = RS_NONE;
        if (alias_hit)              sel = RS_ALIAS;
        else if (bus_addr == A_MODE) sel = RS_MODE;
        else if (bus_addr == A_DOUT) sel = RS_DOUT;
        else if (bus_addr == A_MASK) sel = RS_MASK;
        else if (bus_addr == A_PIN)  sel = RS_PIN;
        else if (bus_addr == A_CTRL) sel = RS_CTRL;
    end

    // Output data update: full-port or single-pin, always under the mask.
    always_comb begin
        upd = '0;
        val = '0;
        if (wr && sel == RS_DOUT) begin
            upd = ~mask_q & IMPL_MASK;
            val = bus_wdata[NPINS-1:0];
        end else if (wr && sel == RS_ALIAS) begin
            upd = (NPINS'(1) << apin) & ~mask_q & IMPL_MASK;
            val = {NPINS{bus_wdata[0]}};
        end
    end
    assign dout_nxt = (dout_q & ~upd) | (val & upd);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            dout_q <= IMPL_MASK;
            mask_q <= '0;
            dis_q  <= '0;
        end else begin
            dout_q <= dout_nxt;
            if (wr && sel == RS_MODE) mode_q <= bus_wdata[2*NPINS-1:0] & IMPL2;
            if (wr && sel == RS_MASK) mask_q <= bus_wdata[NPINS-1:0] & IMPL_MASK;
            if (wr && sel == RS_CTRL) dis_q  <= bus_wdata[DIS_SHIFT +: NPINS] & IMPL_MASK;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (sel)
                RS_MODE:  bus_rdata = DATA_W'(mode_q);
                RS_DOUT:  bus_rdata = DATA_W'(dout_q);
                RS_MASK:  bus_rdata = DATA_W'(mask_q);
                RS_PIN:   bus_rdata = DATA_W'(pin_val);
                RS_CTRL:  bus_rdata = DATA_W'(dis_q) << DIS_SHIFT;
                RS_ALIAS: bus_rdata = DATA_W'(pin_val[apin]);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int               NPINS       = 16,
    parameter logic [NPINS-1:0] IMPL_MASK   = '1,
    parameter int               ADDR_W      = 8,
    parameter int               DATA_W      = 32,
    parameter int               SYNC_STAGES = 2,
    parameter int               BOOST_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_o,
    output logic [NPINS-1:0]  pad_wkpu,
    output logic [NPINS-1:0]  pin_sync
);
    logic [2*NPINS-1:0] mode_q;
    logic [NPINS-1:0]   dout_q;
    logic [NPINS-1:0]   mask_q;
    logic [NPINS-1:0]   dis_q;
    logic [NPINS-1:0]   sync_q;

    gpio_insync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .q   (sync_q)
    );

    assign pin_sync = sync_q & ~dis_q & IMPL_MASK;

    gpio_regs #(
        .NPINS(NPINS), .IMPL_MASK(IMPL_MASK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_val   (pin_sync),
        .bus_rdata (bus_rdata),
        .mode_q    (mode_q),
        .dout_q    (dout_q),
        .mask_q    (mask_q),
        .dis_q     (dis_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        if (IMPL_MASK[i]) begin : g_live
            pad_drv_t drv;
            gpio_pin_drv #(.BOOST_CYC(BOOST_CYC)) u_drv (
                .clk  (clk),
                .rst  (rst),
                .mode (pin_mode_e'(mode_q[2*i +: 2])),
                .dbit (dout_q[i]),
                .drv  (drv)
            );
            assign pad_oe[i]   = drv.oe;
            assign pad_o[i]    = drv.o;
            assign pad_wkpu[i] = drv.wkpu;
        end else begin : g_dead
            assign pad_oe[i]   = 1'b0;
            assign pad_o[i]    = 1'b0;
            assign pad_wkpu[i] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int               NPINS     = 16,
    parameter logic [NPINS-1:0] IMPL_MASK = '1
) (
    input logic               clk,
    input logic               rst,
    input logic [2*NPINS-1:0] mode_q,
    input logic [NPINS-1:0]   dout_q,
    input logic [NPINS-1:0]   mask_q,
    input logic [NPINS-1:0]   pin_i,
    input logic [NPINS-1:0]   pad_oe,
    input logic [NPINS-1:0]   pad_o,
    input logic [NPINS-1:0]   pad_wkpu,
    input logic [NPINS-1:0]   pin_sync
);
    logic [NPINS-1:0] is_pp, is_od, is_qb, hi;

    always_comb begin
        for (int k = 0; k < NPINS; k++) begin
            is_pp[k] = (mode_q[2*k +: 2] == 2'd1);
            is_od[k] = (mode_q[2*k +: 2] == 2'd2);
            is_qb[k] = (mode_q[2*k +: 2] == 2'd3);
        end
    end
    assign hi = pad_oe & pad_o;

    AST_PUSHPULL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & is_pp) == is_pp) && ((pad_o & is_pp) == (dout_q & is_pp))); // R2

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
        (hi & is_od) == '0); // R3

    AST_QUASI_BOOST_MAX: assert property (@(posedge clk) disable iff (rst)
        (hi & $past(hi) & $past(hi, 2) & is_qb) == '0); // R4

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dout_q & $past(mask_q)) == ($past(dout_q) & $past(mask_q))); // R5

    AST_SYNC_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (pin_sync & ~$past(pin_i, 2)) == '0); // R7

    AST_UNIMPL_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe | pad_o | pad_wkpu | pin_sync) & ~IMPL_MASK) == '0); // R10
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .IMPL_MASK(IMPL_MASK)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_q   (mode_q),
    .dout_q   (dout_q),
    .mask_q   (mask_q),
    .pin_i    (pin_i),
    .pad_oe   (pad_oe),
    .pad_o    (pad_o),
    .pad_wkpu (pad_wkpu),
    .pin_sync (pin_sync)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    localparam logic [15:0] IMPL = 16'h0FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_i = '0;
    logic [15:0] pad_oe, pad_o, pad_wkpu, pin_sync;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port #(.NPINS(16), .IMPL_MASK(IMPL)) u_gpio_port (
        .clk, .rst, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .pin_i, .pad_oe, .pad_o, .pad_wkpu, .pin_sync
    );

    // {mode[5:4], dout[3], exp_oe[2], exp_o[1], exp_wkpu[0]}, settled state
    localparam logic [5:0] VEC [8] = '{
        6'b00_0_000, 6'b00_1_000,
        6'b01_0_100, 6'b01_1_110,
        6'b10_0_100, 6'b10_1_000,
        6'b11_0_100, 6'b11_1_001
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        br(8'h00, rd); chk("R1 mode", rd, 32'h0);
        br(8'h04, rd); chk("R1 dout", rd, 32'h0000_0FFF);
        br(8'h08, rd); chk("R1 mask", rd, 32'h0);
        br(8'h10, rd); chk("R1 ctrl", rd, 32'h0);
        chk("R1 pad_oe", {16'h0, pad_oe}, 32'h0);

        // R2 R3 R4 settled pad drive per mode and data
        foreach (VEC[v]) begin
            bw(8'h00, {16{VEC[v][5:4]}});
            bw(8'h04, VEC[v][3] ? 32'h0000_FFFF : 32'h0);
            repeat (4) @(negedge clk);
            chk("R2/R3/R4 pin0 drive", {29'h0, pad_oe[0], pad_o[0], pad_wkpu[0]}, {29'h0, VEC[v][2:0]});
            chk("R2/R3/R4 pin7 drive", {29'h0, pad_oe[7], pad_o[7], pad_wkpu[7]}, {29'h0, VEC[v][2:0]});
        end

        // R4 quasi boost timing on pin 3
        bw(8'h00, 32'hFFFF_FFFF);
        bw(8'h04, 32'h0);
        chk("R4 quasi low strong", {30'h0, pad_oe[3], pad_o[3]}, 32'h3 & 32'h2);
        bw(8'h4C, 32'h1);
        chk("R4 boost cycle 1", {29'h0, pad_oe[3], pad_o[3], pad_wkpu[3]}, 32'b110);
        chk("R9 alias leaves pin4", {30'h0, pad_oe[4], pad_o[4]}, 32'b10);
        @(negedge clk);
        chk("R4 boost cycle 2", {29'h0, pad_oe[3], pad_o[3], pad_wkpu[3]}, 32'b110);
        @(negedge clk);
        chk("R4 weak after boost", {29'h0, pad_oe[3], pad_o[3], pad_wkpu[3]}, 32'b001);

        // R5 R6 mask and full-port writes, push-pull everywhere
        bw(8'h00, 32'h5555_5555);
        br(8'h00, rd); chk("R10 mode readback", rd, 32'h0055_5555);
        bw(8'h04, 32'h0000_FFFF);
        bw(8'h08, 32'h0000_00F0);
        br(8'h08, rd); chk("R5 mask readback", rd, 32'h0000_00F0);
        bw(8'h04, 32'h0);
        br(8'h04, rd); chk("R5 masked bits kept", rd, 32'h0000_00F0);
        chk("R6 pads follow", {16'h0, pad_o}, 32'h0000_00F0);
        bw(8'h54, 32'h0);
        br(8'h04, rd); chk("R5 alias write masked", rd, 32'h0000_00F0);
        bw(8'h44, 32'h1);
        br(8'h04, rd); chk("R9 alias write pin1", rd, 32'h0000_00F2);
        bw(8'h08, 32'h0);
        bw(8'h04, 32'h0000_1234);
        chk("R6 pads after full write", {16'h0, pad_o}, 32'h0000_0234);
        br(8'h04, rd); chk("R10 dout ignores pin12", rd, 32'h0000_0234);
        chk("R10 pad_oe dead pins", {16'h0, pad_oe}, 32'h0000_0FFF);

        // R7 synchronizer latency
        pin_i = 16'hA5A5;
        @(negedge clk);
        br(8'h0C, rd); chk("R7 one edge still old", rd, 32'h0);
        @(negedge clk);
        br(8'h0C, rd); chk("R7 two edges new", rd, 32'h0000_05A5);
        chk("R7 pin_sync port", {16'h0, pin_sync}, 32'h0000_05A5);

        // R9 alias reads, R10 dead pin in alias window
        br(8'h40, rd); chk("R9 alias read pin0", rd, 32'h1);
        br(8'h44, rd); chk("R9 alias read pin1", rd, 32'h0);
        br(8'h74, rd); chk("R10 alias read pin13", rd, 32'h0);

        // R8 input disable
        bw(8'h10, 32'h0001_0004);
        br(8'h10, rd); chk("R8 ctrl low bits ignored", rd, 32'h0001_0000);
        br(8'h0C, rd); chk("R8 pin0 disabled", rd, 32'h0000_05A4);
        br(8'h40, rd); chk("R8 alias pin0 disabled", rd, 32'h0);
        chk("R8 pin_sync gated", {16'h0, pin_sync}, 32'h0000_05A4);
        bw(8'h10, 32'hFFFF_0000);
        br(8'h10, rd); chk("R10 ctrl dead bits", rd, 32'h0FFF_0000);
        bw(8'h10, 32'h0);
        br(8'h0C, rd); chk("R8 re-enabled", rd, 32'h0000_05A5);

        summary();
    end
endmodule